// File: doc/BRIEF.md
# Scaled Effective Address Generator

This block forms the memory address an instruction refers to from up to four ingredients: a base register value, an index register value, a power-of-two scale applied to the index, and a signed displacement carried in the instruction. A two-bit mode code chooses which terms take part. The choices are the displacement alone, base plus displacement, base plus index plus displacement, and base plus scaled index plus displacement. The scale code picks an element size of 1, 2, 4 or 8 bytes. A base term can then point at the start of a row or record, the scaled index selects an element of that size, and the displacement selects a field or an offset that may lie before or after the base.

The displacement is narrower than the address. It is sign-extended before the sum. All arithmetic wraps modulo two to the power of the address width, and no overflow is flagged. A request is presented with an input valid strobe. The address comes out of a register one clock later with its own valid flag, and the address is held until the next request. The parameters require the displacement width to be smaller than the address width.

Top module: `eff_addr_gen`

## Requirements
- R1: In the first clock after synchronous reset is released, `ea_valid` is 0 and `ea_addr` is 0.
- R2: `ea_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low.
- R3: Mode code 2'b00 (displacement only) gives the sign-extended displacement as the address. The base, index and scale inputs have no effect.
- R4: Mode code 2'b01 (base) gives base plus sign-extended displacement. The index and scale inputs have no effect.
- R5: Mode code 2'b10 (base plus index) gives base plus index plus sign-extended displacement. The scale code has no effect.
- R6: Mode code 2'b11 (scaled) gives base plus index times 2^scale_code plus sign-extended displacement. Scale codes 2'b00, 2'b01, 2'b10 and 2'b11 mean factors of 1, 2, 4 and 8.
- R7: The displacement is two's complement. When its top bit is set, the address lies below the base.
- R8: The sum wraps modulo 2^ADDR_W, with no trap or flag.
- R9: While `in_valid` is low, `ea_addr` keeps the last computed address, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Addressing mode code |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| base_val | input | ADDR_W | Base register value |
| index_val | input | ADDR_W | Index register value |
| disp | input | DISP_W | Signed displacement |
| ea_valid | output | 1 | Address valid, one cycle after request |
| ea_addr | output | ADDR_W | Registered effective address |

## Verification
The bench builds the block with a 16-bit address and an 8-bit displacement. With these widths the wrap past 0xFFFF and the sign boundary at displacement 0x80 are reached with small operand values. Each expected address comes from integer arithmetic with an explicit multiply by the scale factor, so it does not depend on the shift the design uses. Every mode is driven with garbage on its unused inputs, so that any leak of an unused term shows up in the address.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;
  typedef enum logic [1:0] {
    AM_DISP   = 2'b00,
    AM_BASE   = 2'b01,
    AM_BIDX   = 2'b10,
    AM_SCALED = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/ea_term_gate.sv
// Forces the base and index terms to zero when the mode leaves them out.
module ea_term_gate
  import eff_addr_pkg::*;
#(
  parameter int W = 32
) (
  input  addr_mode_e     mode,
  input  logic [W-1:0]   base_in,
  input  logic [W-1:0]   index_in,
  output logic [W-1:0]   base_out,
  output logic [W-1:0]   index_out,
  output logic           scale_en
);
  always_comb begin
    base_out  = '0;
    index_out = '0;
    scale_en  = 1'b0;
    unique case (mode)
      AM_DISP: ;
      AM_BASE: base_out = base_in;
      AM_BIDX: begin
        base_out  = base_in;
        index_out = index_in;
      end
      AM_SCALED: begin
        base_out  = base_in;
        index_out = index_in;
        scale_en  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_index_scaler.sv
// Shifts the index left by 0..3 bits; only scaled mode enables the shift.
module ea_index_scaler #(
  parameter int W = 32
) (
  input  logic [W-1:0] index_in,
  input  logic [1:0]   shamt,
  input  logic         enable,
  output logic [W-1:0] index_out
);
  logic [1:0] eff_shamt;
  assign eff_shamt = enable ? shamt : 2'd0;

  always_comb begin
    unique case (eff_shamt)
      2'd0: index_out = index_in;
      2'd1: index_out = {index_in[W-2:0], 1'b0};
      2'd2: index_out = {index_in[W-3:0], 2'b00};
      2'd3: index_out = {index_in[W-4:0], 3'b000};
      default: index_out = index_in;
    endcase
  end
endmodule

// File: rtl/ea_sum3.sv
// Three-operand modular adder.
module ea_sum3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);
  assign sum = a + b + c;
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eff_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [1:0]        scale_code,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [DISP_W-1:0] disp,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] index_scaled;
  logic [ADDR_W-1:0] sum_next;
  logic              scale_en;

  // sign extension of the displacement
  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  ea_term_gate #(.W(ADDR_W)) u_gate (
    .mode      (addr_mode_e'(mode)),
    .base_in   (base_val),
    .index_in  (index_val),
    .base_out  (base_term),
    .index_out (index_term),
    .scale_en  (scale_en)
  );

  ea_index_scaler #(.W(ADDR_W)) u_scale (
    .index_in  (index_term),
    .shamt     (scale_code),
    .enable    (scale_en),
    .index_out (index_scaled)
  );

  ea_sum3 #(.W(ADDR_W)) u_sum (
    .a   (base_term),
    .b   (index_scaled),
    .c   (disp_ext),
    .sum (sum_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
    end else begin
      ea_valid <= in_valid;
      if (in_valid) ea_addr <= sum_next;
    end
  end
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic [1:0]        scale_code,
  input logic [ADDR_W-1:0] base_val,
  input logic [ADDR_W-1:0] index_val,
  input logic [DISP_W-1:0] disp,
  input logic              ea_valid,
  input logic [ADDR_W-1:0] ea_addr
);
  logic [ADDR_W-1:0] d_sx;
  logic [ADDR_W-1:0] factor;
  assign d_sx   = ADDR_W'($signed(disp));
  assign factor = ADDR_W'(1) << scale_code;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ea_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !ea_valid);
  // R3
  disp_only_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=> ea_addr == $past(d_sx));
  // R4
  base_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=> ea_addr == ADDR_W'($past(base_val) + $past(d_sx)));
  // R5
  bidx_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b10) |=>
      ea_addr == ADDR_W'($past(base_val) + $past(index_val) + $past(d_sx)));
  // R6
  scaled_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b11) |=>
      ea_addr == ADDR_W'($past(base_val) + $past(index_val) * $past(factor) + $past(d_sx)));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ea_addr));
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .mode       (mode),
  .scale_code (scale_code),
  .base_val   (base_val),
  .index_val  (index_val),
  .disp       (disp),
  .ea_valid   (ea_valid),
  .ea_addr    (ea_addr)
);

// File: tb/test_eff_addr_gen.sv
module test_eff_addr_gen;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    mode = '0;
  logic [1:0]    scale_code = '0;
  logic [AW-1:0] base_val = '0;
  logic [AW-1:0] index_val = '0;
  logic [DW-1:0] disp = '0;
  logic          ea_valid;
  logic [AW-1:0] ea_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eff_addr_gen #(.ADDR_W(AW), .DISP_W(DW)) i_eff_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .scale_code(scale_code), .base_val(base_val), .index_val(index_val),
    .disp(disp), .ea_valid(ea_valid), .ea_addr(ea_addr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model(int m, int s, longint b, longint i, longint d_raw);
    longint d, bt, it, mul, tot;
    d   = (d_raw >= (1 << (DW-1))) ? d_raw - (1 << DW) : d_raw;
    bt  = (m >= 1) ? b : 0;
    it  = (m >= 2) ? i : 0;
    mul = (m == 3) ? (1 << s) : 1;
    tot = bt + it * mul + d;
    return tot[AW-1:0];
  endfunction

  // drive one request, leave in_valid low afterwards; output visible at return
  task automatic issue(int m, int s, int b, int i, int d);
    @(negedge clk);
    mode = 2'(m); scale_code = 2'(s);
    base_val = AW'(b); index_val = AW'(i); disp = DW'(d);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_req(string req, int m, int s, int b, int i, int d);
    issue(m, s, b, i, d);
    check(req, ea_valid, 1);
    check(req, ea_addr, model(m, s, b, i, d));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid", ea_valid, 0);
    check("R1 addr", ea_addr, 0);
  endtask

  task automatic t_disp_only;
    run_req("R3", 0, 3, 16'h1234, 16'h0055, 8'h10);
    check("R3 value", ea_addr, 16'h0010);
    run_req("R3 R7 negative", 0, 2, 16'hAAAA, 16'h5555, 8'h80);
    check("R7 value", ea_addr, 16'hFF80);
  endtask

  task automatic t_base;
    run_req("R4", 1, 3, 16'h1000, 16'h7777, 8'h20);
    check("R4 value", ea_addr, 16'h1020);
    run_req("R4 R7", 1, 1, 16'h1000, 16'h0123, 8'hFE);
    check("R7 below base", ea_addr, 16'h0FFE);
  endtask

  task automatic t_bidx;
    run_req("R5", 2, 3, 16'h1000, 16'h0010, 8'h02);
    check("R5 value", ea_addr, 16'h1012);
  endtask

  task automatic t_scaled;
    for (int s = 0; s < 4; s++) begin
      run_req("R6", 3, s, 16'h0100, 16'h0010, 8'h04);
      check("R6 value", ea_addr, 16'h0104 + (16'h0010 << s));
    end
    run_req("R6 R7", 3, 3, 16'h2000, 16'h0004, 8'hF0);
  endtask

  task automatic t_wrap;
    run_req("R8", 2, 0, 16'hFFF0, 16'h0020, 8'h00);
    check("R8 value", ea_addr, 16'h0010);
    run_req("R8 scaled", 3, 1, 16'h0001, 16'h8001, 8'h01);
    check("R8 scaled value", ea_addr, 16'h0004);
    run_req("R8 R7 under zero", 1, 0, 16'h0003, 16'h0000, 8'hF8);
    check("R8 under value", ea_addr, 16'hFFFB);
  endtask

  task automatic t_idle_hold;
    logic [AW-1:0] held;
    run_req("R2", 3, 2, 16'h0400, 16'h0003, 8'h01);
    held = ea_addr;
    @(negedge clk);
    mode = 2'b10; base_val = 16'hBEEF; index_val = 16'h1111; disp = 8'h33;
    check("R2 drop", ea_valid, 0);
    check("R9 hold", ea_addr, held);
    repeat (3) @(negedge clk);
    check("R9 hold later", ea_addr, held);
    check("R2 still low", ea_valid, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    mode = 2'b01; base_val = 16'h0200; disp = 8'h08; in_valid = 1'b1;
    @(negedge clk);
    check("R2 first", ea_valid, 1);
    check("R4 first", ea_addr, 16'h0208);
    mode = 2'b00; disp = 8'h7F;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second", ea_valid, 1);
    check("R3 second", ea_addr, 16'h007F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disp_only();
    t_base();
    t_bidx();
    t_scaled();
    t_wrap();
    t_idle_hold();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule